// File: doc/BRIEF.md
# External Interrupt Input Qualifier

This block conditions a single external interrupt pin for a small microcontroller. The raw pin goes through a two-flop synchronizer and a polarity inverter. A width filter then updates a clean level only after the new value has held for a programmable number of system clock cycles. Because the width is counted in clocks, the minimum accepted pulse scales with whichever oscillator drives the core. The clean level can also be read as an ordinary input port bit, so software can decode slow serial signals such as remote-control frames from the same pin.

Transitions of the clean level become events, either on its rising or on its falling edge. In direct mode each event makes the vector-1 request pending. In count mode the events clock an 8-bit counter instead. When the counter reaches a programmed compare value, the vector-3 request becomes pending and the counter restarts from zero. Both requests are sticky until the CPU acknowledges them.

Top module: `ext_irq_qual`

## Requirements
- R1: The port bit follows the synchronized, polarity-adjusted pin only after that level has differed from the port bit for `cfg_filt_len` consecutive cycles. A pin change held that long appears on `port_bit` exactly `cfg_filt_len`+2 clock edges after it is applied. A pulse one cycle shorter leaves `port_bit` and both requests unchanged. A length of 0 acts as 1.
- R2: With `cfg_invert`=1 the conditioned level is the inverse of the pin, so `port_bit` reads 1 while the pin is held low.
- R3: With `cfg_edge_fall`=0 an event is a 0-to-1 change of `port_bit`. With `cfg_edge_fall`=1 an event is a 1-to-0 change. An accepted pulse therefore produces exactly one event.
- R4: In direct mode (`cfg_count_mode`=0) with `cfg_enable`=1, `req_v1` is 1 from the edge on which an event's `port_bit` change appears.
- R5: `req_v1` and `req_v3` stay 1 until a cycle with their acknowledge high, and read 0 on the next cycle. If an event sets the flag in the same cycle as its acknowledge, the flag stays 1.
- R6: With `cfg_enable`=0 neither request is set, but `port_bit` still follows the filtered pin.
- R7: In count mode with `cfg_enable`=1, events do not set `req_v1`. The `cfg_cmp`-th event since the counter was last zero sets `req_v3` and returns the counter to zero. A compare value of 0 is reached after 256 events.
- R8: While count mode or enable is off, the event counter is held at zero, so counting restarts after the mode is re-entered.
- R9: After reset `port_bit`, `req_v1` and `req_v3` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Raw external interrupt pin (asynchronous) |
| cfg_enable | input | 1 | Allows requests to be set |
| cfg_invert | input | 1 | Inverts the pin level before filtering |
| cfg_edge_fall | input | 1 | 0: rising event, 1: falling event |
| cfg_count_mode | input | 1 | 0: direct vector 1, 1: event counter with vector 3 |
| cfg_filt_len | input | FILT_W | Minimum accepted width in clock cycles |
| cfg_cmp | input | CNT_W | Event count compare value |
| ack_v1 | input | 1 | Clears the vector-1 request |
| ack_v3 | input | 1 | Clears the vector-3 request |
| req_v1 | output | 1 | Pending request for vector 1 |
| req_v3 | output | 1 | Pending request for vector 3 |
| port_bit | output | 1 | Conditioned pin level for port reads |

## Verification
Random pulse widths from one cycle up to twice the filter length sit on both sides of the width threshold. They are run with either edge selected, which tells a correct filter apart from one that is one cycle short or one cycle long. Directed pulses of exactly the threshold and one less pin down the boundary, and a timed step checks the edge on which `port_bit` moves. Count-mode runs with random compare values separate a counter that fires on the right event from one that is off by one or ignores its reset on mode exit. A pulse timed so that its event lands on an acknowledge cycle checks that a new event wins over the acknowledge.

// File: rtl/ext_irq_qual.sv
module ext_irq_qual #(
  parameter int FILT_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_raw,
  input  logic              cfg_enable,
  input  logic              cfg_invert,
  input  logic              cfg_edge_fall,
  input  logic              cfg_count_mode,
  input  logic [FILT_W-1:0] cfg_filt_len,
  input  logic [CNT_W-1:0]  cfg_cmp,
  input  logic              ack_v1,
  input  logic              ack_v3,
  output logic              req_v1,
  output logic              req_v3,
  output logic              port_bit
);

  logic              sync1, sync2;
  logic              filt;
  logic [FILT_W-1:0] fcnt;
  logic [CNT_W-1:0]  ecnt;

  wire              cond    = sync2 ^ cfg_invert;
  wire [FILT_W-1:0] thr_m1  = (cfg_filt_len == '0) ? '0 : cfg_filt_len - 1'b1;
  wire              differ  = cond != filt;
  wire              upd     = differ && (fcnt == thr_m1);
  wire              evt     = upd && (cond ^ cfg_edge_fall);
  wire              cnt_on  = cfg_enable && cfg_count_mode;
  wire [CNT_W-1:0]  ecnt_nx = ecnt + 1'b1;
  wire              hit     = evt && cnt_on && (ecnt_nx == cfg_cmp);
  wire              set_v1  = evt && cfg_enable && !cfg_count_mode;

  assign port_bit = filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= pin_raw;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt <= 1'b0;
      fcnt <= '0;
    end else if (!differ) begin
      fcnt <= '0;
    end else if (upd) begin
      filt <= cond;
      fcnt <= '0;
    end else begin
      fcnt <= fcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ecnt <= '0;
    else if (!cnt_on) ecnt <= '0;
    else if (evt)    ecnt <= hit ? '0 : ecnt_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_v1 <= 1'b0;
      req_v3 <= 1'b0;
    end else begin
      req_v1 <= set_v1 | (req_v1 & ~ack_v1);
      req_v3 <= hit    | (req_v3 & ~ack_v3);
    end
  end

  // R1: a port change always takes the conditioned level seen on the prior cycle
  a_r1_port_from_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (port_bit != $past(port_bit)) |-> (port_bit == $past(cond)));

  // R5: pending flags hold without acknowledge
  a_r5_v1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (req_v1 && !ack_v1) |=> req_v1);
  a_r5_v3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (req_v3 && !ack_v3) |=> req_v3);

  // R6: disabled block raises nothing new
  a_r6_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && !req_v1 && !req_v3) |=> (!req_v1 && !req_v3));

  // R4/R7: each vector rises only in its own mode
  a_r4_v1_direct_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_v1) |-> $past(cfg_enable && !cfg_count_mode));
  a_r7_v3_count_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_v3) |-> $past(cfg_enable && cfg_count_mode));

  // R8: counter idle outside count mode
  a_r8_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_on) |-> (ecnt == '0));

endmodule

// File: tb/test_ext_irq_qual.sv
`timescale 1ns/1ps
module test_ext_irq_qual;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_raw = 1'b0;
  logic       cfg_enable = 1'b0, cfg_invert = 1'b0, cfg_edge_fall = 1'b0, cfg_count_mode = 1'b0;
  logic [7:0] cfg_filt_len = 8'd8;
  logic [7:0] cfg_cmp = 8'd1;
  logic       ack_v1 = 1'b0, ack_v3 = 1'b0;
  logic       req_v1, req_v3, port_bit;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_qual #(.FILT_W(8), .CNT_W(8)) i_ext_irq_qual (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw),
    .cfg_enable(cfg_enable), .cfg_invert(cfg_invert), .cfg_edge_fall(cfg_edge_fall),
    .cfg_count_mode(cfg_count_mode), .cfg_filt_len(cfg_filt_len), .cfg_cmp(cfg_cmp),
    .ack_v1(ack_v1), .ack_v3(ack_v3),
    .req_v1(req_v1), .req_v3(req_v3), .port_bit(port_bit));

  function automatic int eff_thr(input int len);
    return (len == 0) ? 1 : len;
  endfunction

  function automatic bit accepted(input int w, input int len);
    return w >= eff_thr(len);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int w, input int gap);
    @(negedge clk); pin_raw = ~pin_raw;
    repeat (w) @(negedge clk);
    pin_raw = ~pin_raw;
    repeat (gap) @(negedge clk);
  endtask

  task automatic ack1;
    @(negedge clk); ack_v1 = 1'b1;
    @(negedge clk); ack_v1 = 1'b0;
  endtask

  task automatic ack3;
    @(negedge clk); ack_v3 = 1'b1;
    @(negedge clk); ack_v3 = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    int thr;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 port_bit", port_bit, 1'b0);
    check("R9 req_v1", req_v1, 1'b0);
    check("R9 req_v3", req_v3, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 exact latency
    cfg_enable = 1'b1;
    thr = 8;
    @(negedge clk); pin_raw = 1'b1;
    repeat (thr + 1) @(negedge clk);
    check("R1 latency early", port_bit, 1'b0);
    @(negedge clk);
    check("R1 latency edge", port_bit, 1'b1);
    check("R4 req on same edge", req_v1, 1'b1);
    pin_raw = 1'b0;
    repeat (thr + 6) @(negedge clk);
    check("R1 level back low", port_bit, 1'b0);
    ack1;
    check("R5 ack clears v1", req_v1, 1'b0);

    // R1 boundary widths
    pulse(thr - 1, thr + 6);
    check("R1 short pulse rejected req", req_v1, 1'b0);
    pulse(thr, thr + 6);
    check("R1 exact width accepted", req_v1, 1'b1);
    ack1;

    // R1 threshold 0 acts as 1
    cfg_filt_len = 8'd0;
    pulse(1, 8);
    check("R1 zero threshold", req_v1, 1'b1);
    ack1;
    cfg_filt_len = 8'd3;
    pulse(2, 10);
    check("R1 len3 short", req_v1, 1'b0);

    // R1/R3/R4 random widths with random edge select
    for (int i = 0; i < 60; i++) begin
      int len = $urandom_range(1, 12);
      int w = $urandom_range(1, 2 * len);
      cfg_filt_len = len[7:0];
      cfg_edge_fall = 1'($urandom_range(0, 1));
      pulse(w, len + 6);
      check("R3 random pulse event", req_v1, accepted(w, len));
      check("R1 random idle level", port_bit, 1'b0);
      ack1;
      check("R5 random ack", req_v1, 1'b0);
    end
    cfg_edge_fall = 1'b0;
    cfg_filt_len = 8'd8;

    // R3 falling select: event only after pulse ends
    cfg_edge_fall = 1'b1;
    @(negedge clk); pin_raw = 1'b1;
    repeat (thr + 4) @(negedge clk);
    check("R3 no event on rise when falling", req_v1, 1'b0);
    pin_raw = 1'b0;
    repeat (thr + 4) @(negedge clk);
    check("R3 event on fall", req_v1, 1'b1);
    ack1;
    cfg_edge_fall = 1'b0;

    // R5 event coincides with acknowledge
    pulse(thr + 2, thr + 6);
    check("R5 pending before race", req_v1, 1'b1);
    @(negedge clk); pin_raw = 1'b1;
    repeat (thr + 1) @(negedge clk);
    ack_v1 = 1'b1;
    @(negedge clk); ack_v1 = 1'b0;
    check("R5 set wins over ack", req_v1, 1'b1);
    pin_raw = 1'b0;
    repeat (thr + 6) @(negedge clk);
    ack1;
    check("R5 cleared after race", req_v1, 1'b0);

    // R6 disabled: port still follows
    cfg_enable = 1'b0;
    @(negedge clk); pin_raw = 1'b1;
    repeat (thr + 4) @(negedge clk);
    check("R6 port follows when disabled", port_bit, 1'b1);
    check("R6 no v1 when disabled", req_v1, 1'b0);
    pin_raw = 1'b0;
    repeat (thr + 6) @(negedge clk);
    check("R6 no v1 after pulse", req_v1, 1'b0);

    // R2 inversion with enable off, then a low pulse is an event
    cfg_invert = 1'b1;
    repeat (thr + 6) @(negedge clk);
    check("R2 inverted idle reads 1", port_bit, 1'b1);
    cfg_enable = 1'b1;
    cfg_edge_fall = 1'b1;
    @(negedge clk); pin_raw = 1'b1;
    repeat (thr + 4) @(negedge clk);
    check("R2 pin high reads 0", port_bit, 1'b0);
    check("R2 fall of inverted level is event", req_v1, 1'b1);
    pin_raw = 1'b0;
    repeat (thr + 6) @(negedge clk);
    ack1;
    cfg_enable = 1'b0;
    cfg_invert = 1'b0;
    cfg_edge_fall = 1'b0;
    repeat (thr + 6) @(negedge clk);
    check("R2 restored idle", port_bit, 1'b0);

    // R7 count mode with random compare values
    cfg_enable = 1'b1;
    cfg_count_mode = 1'b1;
    for (int r = 0; r < 6; r++) begin
      int c = $urandom_range(1, 5);
      cfg_cmp = c[7:0];
      for (int p = 1; p <= c; p++) begin
        pulse(thr + 2, thr + 6);
        check("R7 v3 at compare", req_v3, p == c);
        check("R7 no v1 in count mode", req_v1, 1'b0);
      end
      ack3;
      check("R5 ack clears v3", req_v3, 1'b0);
    end

    // R7 short pulses do not count
    cfg_cmp = 8'd1;
    pulse(thr - 1, thr + 6);
    check("R7 short pulse not counted", req_v3, 1'b0);

    // R8 leaving count mode clears the counter
    cfg_cmp = 8'd3;
    pulse(thr + 2, thr + 6);
    pulse(thr + 2, thr + 6);
    cfg_count_mode = 1'b0;
    @(negedge clk);
    cfg_count_mode = 1'b1;
    pulse(thr + 2, thr + 6);
    pulse(thr + 2, thr + 6);
    check("R8 restart not early", req_v3, 1'b0);
    pulse(thr + 2, thr + 6);
    check("R8 restart fires on third", req_v3, 1'b1);
    ack3;

    // R7 compare 0 wraps after 256 events
    cfg_cmp = 8'd0;
    cfg_filt_len = 8'd2;
    for (int p = 1; p <= 256; p++) begin
      pulse(3, 6);
      if (p == 255) check("R7 cmp0 not at 255", req_v3, 1'b0);
    end
    check("R7 cmp0 fires at 256", req_v3, 1'b1);
    ack3;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule